// File: doc/BRIEF.md
# Pin Data Register Bank with Atomic Set/Clear Aliases

This block holds the output data word and the direction word for a bank of general-purpose pins and captures the pin levels into a synchronized input word. A host reaches it over a simple single-cycle register bus. Each access carries a word index, a write strobe, a 32-bit data word and one byte-lane enable per byte. Lane 0 carries bits 7:0 (little-endian), so 8-, 16- and 32-bit accesses are all expressed through the lane enables. Reads are combinational on the word index.

The output data word can be replaced directly. It can also be changed bit by bit through two alias words, one that sets and one that clears. These let software change single pins without a read-modify-write. Reading either alias returns the output data word. The direction word uses 1 for input and 0 for output, and resets to all ones, so every pin starts as an input.

Word map (word index): 0 input word (read only), 1 direction word, 2 output data word, 3 set alias, 4 clear alias, 5 to 7 unmapped.

Top module: `sc_gpio_bank`

## Requirements
- R1: After synchronous reset the output data word is 0x0000_0000. The direction word is 0xFFFF_FFFF, so pad_drive_en is all zero. The input word reads 0 while pad_in is 0.
- R2: A write to word 2 replaces only the bytes whose lane enable is 1. Lane n covers bits 8n+7:8n. The other bytes keep their value.
- R3: A write to word 3 sets every output data bit whose write-data bit is 1 in an enabled lane. All other bits are unchanged.
- R4: A write to word 4 clears every output data bit whose write-data bit is 1 in an enabled lane. All other bits are unchanged. Example: 0x0000_0101 cleared with 0x0000_0001 gives 0x0000_0100.
- R5: A read of word 3 or of word 4 returns the current output data word.
- R6: A write to word 1 updates the enabled bytes of the direction word. pad_drive_en bit k is 1 exactly when direction bit k is 0. pad_out always presents the output data word.
- R7: An output data change made by a write appears on pad_out at the rising clock edge that accepts the write, and not before.
- R8: A change on pad_in that is set up before rising edge e reads from word 0 after edge e+1, and not after edge e only.
- R9: Writes to word 0 and to unmapped words 5 to 7 change no register. Reads of unmapped words return 0.
- R10: Lane enables restrict the set and clear aliases in the same way as direct writes.
- R11: With bus_valid low, no register changes, whatever the write strobe and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index |
| bus_be | input | 4 | Byte-lane enables, lane 0 = bits 7:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Output data to the pads |
| pad_drive_en | output | 32 | Per-pin output driver enable, 1 = drive |

## Verification
The hardest case to reach is an alias write limited to some byte lanes. Here the set or clear must act inside the enabled lanes and leave the remaining bits alone. Bits that are already 1 must survive a clear in a disabled lane. The vector table therefore first loads a mixed pattern through a partial direct write. It then sets all ones on the top lane only and clears all ones on lane 1 only. Each result is read back through the output data word and through both aliases. The two-edge input latency is reached by changing pad_in just after a falling edge and sampling the input word after one and after two rising edges.

// File: rtl/sc_gpio_pkg.sv
// Shared word indices and decode type for the pin data register bank.
// Assumes a 3-bit word index; the index values are fixed by the software map.
package sc_gpio_pkg;
    localparam int ADDR_W   = 3;
    localparam logic [ADDR_W-1:0] IDX_DIN  = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_DOUT = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_SET  = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_CLR  = 3'd4;

    typedef struct packed {
        logic din;
        logic dir;
        logic dout;
        logic set;
        logic clr;
    } word_sel_t;
endpackage

// File: rtl/sc_gpio_decode.sv
// Bus decoder: turns the word index into one-hot write selects and a
// read select. It also expands the byte-lane enables into a per-bit mask.
// Assumes a single-cycle bus; a write is accepted when valid and write are high.
module sc_gpio_decode
    import sc_gpio_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    output word_sel_t         wr_sel,
    output word_sel_t         rd_sel,
    output logic [DATA_W-1:0] bit_mask
);
    logic wr_go;

    // Accept a write only on a valid write access.
    assign wr_go = bus_valid & bus_write;

    // Read select from the index alone.
    always_comb begin
        rd_sel      = '0;
        rd_sel.din  = (bus_addr == IDX_DIN);
        rd_sel.dir  = (bus_addr == IDX_DIR);
        rd_sel.dout = (bus_addr == IDX_DOUT);
        rd_sel.set  = (bus_addr == IDX_SET);
        rd_sel.clr  = (bus_addr == IDX_CLR);
    end

    // Write select: input word is read only, so its strobe is never raised.
    always_comb begin
        wr_sel      = '0;
        wr_sel.dir  = wr_go & rd_sel.dir;
        wr_sel.dout = wr_go & rd_sel.dout;
        wr_sel.set  = wr_go & rd_sel.set;
        wr_sel.clr  = wr_go & rd_sel.clr;
    end

    // Expand each lane enable over its eight bits (little-endian lanes).
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign bit_mask[8*g +: 8] = {8{bus_be[g]}};
    end

    // At most one register is written per cycle (R9).
    p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // No write select without a valid strobe (R11).
    p_no_write_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (wr_sel == '0));
endmodule

// File: rtl/sc_gpio_word_reg.sv
// One register word that can be replaced under a bit mask, or have bits set
// or cleared under that mask. Used for both the output data and the direction word.
// Assumes at most one of wr_en, set_en and clr_en is high in any cycle.
module sc_gpio_word_reg #(
    parameter int               DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] hit;
    logic [DATA_W-1:0] q_next;

    // Bits selected by both the data and the lane mask.
    assign hit = data & mask;

    // Next-value selection for direct, set and clear updates.
    always_comb begin
        q_next = q;
        if (wr_en)  q_next = (q & ~mask) | hit;
        if (set_en) q_next = q | hit;
        if (clr_en) q_next = q & ~hit;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= q_next;
    end

    // Reset value is loaded (R1).
    p_reset_val_r1: assert property (@(posedge clk)
        !rst_n |=> (q == RESET_VAL));

    // Set alias raises the selected bits (R3).
    p_set_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & $past(hit)) == $past(hit)));

    // Set alias keeps the unselected bits (R3, R10).
    p_set_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((q & ~$past(hit)) == ($past(q) & ~$past(hit))));

    // Clear alias drops the selected bits (R4).
    p_clr_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & $past(hit)) == '0));

    // Clear alias keeps the unselected bits (R4, R10).
    p_clr_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((q & ~$past(hit)) == ($past(q) & ~$past(hit))));

    // Direct write leaves disabled lanes alone (R2).
    p_wr_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));

    // No strobe, no change (R11).
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || set_en || clr_en) |=> $stable(q));
endmodule

// File: rtl/sc_gpio_in_sync.sv
// Two-flop capture of the pad levels into the input word.
// Assumes pad_in may be asynchronous; the second stage is the readable word.
module sc_gpio_in_sync #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] din_q
);
    logic [DATA_W-1:0] meta_q;

    // Two-stage synchronizer with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            din_q  <= '0;
        end else begin
            meta_q <= pad_in;
            din_q  <= meta_q;
        end
    end

    // Input word equals the pad level two edges earlier (R8).
    p_two_edge_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (din_q == $past(pad_in, 2)));
endmodule

// File: rtl/sc_gpio_bank.sv
// Pin data register bank: output data word with set/clear aliases, a direction
// word (1 = input), and a synchronized input word, on a single-cycle register bus.
// Assumes bus_rdata is sampled by the host in the cycle bus_addr is presented.
module sc_gpio_bank
    import sc_gpio_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_drive_en
);
    word_sel_t         wr_sel;
    word_sel_t         rd_sel;
    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] dout_q;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] din_q;

    sc_gpio_decode #(.DATA_W(DATA_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel),
        .bit_mask  (bit_mask)
    );

    sc_gpio_word_reg #(.DATA_W(DATA_W), .RESET_VAL('0)) u_dout (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_sel.dout),
        .set_en (wr_sel.set),
        .clr_en (wr_sel.clr),
        .mask   (bit_mask),
        .data   (bus_wdata),
        .q      (dout_q)
    );

    sc_gpio_word_reg #(.DATA_W(DATA_W), .RESET_VAL('1)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_sel.dir),
        .set_en (1'b0),
        .clr_en (1'b0),
        .mask   (bit_mask),
        .data   (bus_wdata),
        .q      (dir_q)
    );

    sc_gpio_in_sync #(.DATA_W(DATA_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .din_q  (din_q)
    );

    // Pad drive: data always presented, driver on where direction bit is 0.
    assign pad_out      = dout_q;
    assign pad_drive_en = ~dir_q;

    // Read mux; both aliases mirror the output data word, unmapped reads 0.
    always_comb begin
        bus_rdata = '0;
        if (rd_sel.din)                           bus_rdata = din_q;
        if (rd_sel.dir)                           bus_rdata = dir_q;
        if (rd_sel.dout | rd_sel.set | rd_sel.clr) bus_rdata = dout_q;
    end

    // Pad data only moves when the output data word was targeted (R7, R9).
    p_pad_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_sel.dout || wr_sel.set || wr_sel.clr) |=> $stable(pad_out));

    // Driver enables only move on a direction write (R6).
    p_drive_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel.dir |=> $stable(pad_drive_en));
endmodule

// File: tb/sc_gpio_bank_tb.sv
module sc_gpio_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_drive_en;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    sc_gpio_bank u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_be       (bus_be),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_drive_en (pad_drive_en)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [2:0]  chk;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Index map: 0 input, 1 direction, 2 data, 3 set alias, 4 clear alias.
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd2, 4'hF, 32'h0000_0101, 3'd2, 32'h0000_0101, 8'd2},  // R2 full
        '{1'b1, 3'd4, 4'hF, 32'h0000_0001, 3'd2, 32'h0000_0100, 8'd4},  // R4
        '{1'b1, 3'd3, 4'hF, 32'h0000_800E, 3'd2, 32'h0000_810E, 8'd3},  // R3
        '{1'b1, 3'd2, 4'h5, 32'hAABB_CCDD, 3'd2, 32'h00BB_81DD, 8'd2},  // R2 lanes
        '{1'b1, 3'd3, 4'h8, 32'hFFFF_FFFF, 3'd2, 32'hFFBB_81DD, 8'd10}, // R10 set
        '{1'b1, 3'd4, 4'h2, 32'hFFFF_FFFF, 3'd2, 32'hFFBB_00DD, 8'd10}, // R10 clr
        '{1'b0, 3'd0, 4'h0, 32'h0000_0000, 3'd3, 32'hFFBB_00DD, 8'd5},  // R5 set
        '{1'b0, 3'd0, 4'h0, 32'h0000_0000, 3'd4, 32'hFFBB_00DD, 8'd5},  // R5 clr
        '{1'b1, 3'd0, 4'hF, 32'h1234_5678, 3'd2, 32'hFFBB_00DD, 8'd9},  // R9 ro
        '{1'b1, 3'd7, 4'hF, 32'h1234_5678, 3'd2, 32'hFFBB_00DD, 8'd9},  // R9 unmap
        '{1'b0, 3'd0, 4'h0, 32'h0000_0000, 3'd5, 32'h0000_0000, 8'd9},  // R9 read
        '{1'b1, 3'd1, 4'h5, 32'h00F0_000F, 3'd1, 32'hFFF0_FF0F, 8'd6}   // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(3'd2, rd); check("R1 data word", rd, 32'h0);
        bus_rd(3'd1, rd); check("R1 direction word", rd, 32'hFFFF_FFFF);
        check("R1 drive enables", pad_drive_en, 32'h0);
        bus_rd(3'd0, rd); check("R1 input word", rd, 32'h0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_wr(VECS[i].addr, VECS[i].be, VECS[i].data);
            bus_rd(VECS[i].chk, rd);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
        end

        // R6 pads follow the registers
        check("R6 drive enables", pad_drive_en, 32'h000F_00F0);
        check("R6 pad data", pad_out, 32'hFFBB_00DD);

        // R11 valid low blocks writes
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 3'd4; bus_be = 4'hF;
        bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_write = 1'b0;
        bus_rd(3'd2, rd); check("R11 data word", rd, 32'hFFBB_00DD);

        // R7 pad change lands on the accepting edge
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd2; bus_be = 4'hF;
        bus_wdata = 32'h0000_005A;
        #1 check("R7 pad before edge", pad_out, 32'hFFBB_00DD);
        @(posedge clk); #1;
        check("R7 pad after edge", pad_out, 32'h0000_005A);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;

        // R8 two-edge input latency
        bus_addr = 3'd0;
        pad_in = 32'hC3C3_0F0F;
        @(posedge clk); #1;
        check("R8 after one edge", bus_rdata, 32'h0);
        @(posedge clk); #1;
        check("R8 after two edges", bus_rdata, 32'hC3C3_0F0F);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule